// File: doc/BRIEF.md
# Frame-Delineated Receive Sample Deframer

This block turns the raw receive stream of a source-synchronous radio interface into parallel per-channel samples. Each interface clock cycle carries two capture points: the rising-edge port and the falling-edge port, which model a double-rate front end. In lane mode a 12-bit sample is split into two 6-bit halves, one on each edge. In wide mode a whole 12-bit sample arrives on the rising edge and the falling port is ignored. Either way, the block receives one sample per cycle.

A framing line travels with the data. It is high for the first half of the samples in a frame and low for the rest. The block watches for a low-to-high change of that line to find the first sample of a frame. It tracks the expected pattern and drops any frame in which the pattern breaks. For each complete frame it presents sign-extended 16-bit samples on four channel outputs in the order I0, Q0, I1, Q1. A single-cycle valid strobe marks each complete frame, so the strobe runs at the per-channel sample rate and not at the interface rate. A single-pair configuration shortens the frame to two samples and drives only the first two channels.

Top module: `rx_frame_deframer`

## Requirements
- R1: In lane mode (`lane_mode`=1) each sample is formed from `rise_data[5:0]` as bits 11:6 and `fall_data[5:0]` as bits 5:0. `rise_data[11:6]` has no effect.
- R2: In wide mode (`lane_mode`=0) each sample is `rise_data[11:0]` taken on one edge. `fall_data` and `fall_frame` have no effect.
- R3: With `one_ch`=0 a frame holds 4 samples. Their frame bits are 1,1,0,0, which in lane mode is 1,1,1,1,0,0,0,0 across the edges. Samples 0..3 of a frame appear on channels 0..3 (`chan_data` bits 16c+15:16c for channel c).
- R4: Each 12-bit sample is sign-extended into its 16-bit channel field.
- R5: `chan_valid` goes high for exactly one cycle per completed frame, on all active channels together. The last sample is presented before clock edge k, and the channel data and the valid strobe update at edge k+1. Between strobes the channel data holds.
- R6: With `one_ch`=1 a frame holds 2 samples with frame bits 1,0. Only `chan_valid[1:0]` are strobed, channels 2 and 3 keep their data, and `r1_mode` is 1.
- R7: A low-to-high change of the frame bit between consecutive samples always starts a new frame at sample 0. This holds even when it arrives before the current frame is complete, in which case the partial frame is dropped and `frame_err` is set.
- R8: When a sample's frame bit differs from the expected pattern, the frame in progress is discarded with no valid strobe and `frame_err` is set. `frame_err` stays set until reset, and the block locks again at the next low-to-high change of the frame bit.
- R9: In lane mode, `rise_frame` and `fall_frame` differing within one cycle is treated as a pattern break under R8.
- R10: `chan_en` equals `chan_en_cfg` at all times, and `r1_mode` equals `one_ch`.
- R11: While `rst_n` is low at a clock edge, `chan_data`, `chan_valid` and `frame_err` become zero.
- R12: Until the first low-to-high change of the frame bit after reset, no valid strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_mode | input | 1 | 1: two edges per sample on 6-bit lanes; 0: one edge per 12-bit sample |
| one_ch | input | 1 | 1: single I/Q pair, 2-sample frames |
| rise_data | input | 12 | Data captured on the rising edge |
| rise_frame | input | 1 | Frame line captured on the rising edge |
| fall_data | input | 6 | Data captured on the falling edge (lane mode only) |
| fall_frame | input | 1 | Frame line captured on the falling edge (lane mode only) |
| chan_en_cfg | input | 4 | Per-channel enable control bits |
| chan_data | output | 64 | Four 16-bit channel samples, channel c at bits 16c+15:16c |
| chan_valid | output | 4 | Per-channel valid strobe |
| chan_en | output | 4 | Per-channel enable, mirrors `chan_en_cfg` |
| r1_mode | output | 1 | Single-pair mode indicator |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The main path is driven with eight back-to-back frames that alternate between lane and wide mode. The samples include extreme positive and negative values, alternating bit patterns and values whose halves differ. These frames show that the halves are placed in the correct order, that the sign bit is extended, and that the slot-to-channel order is right. The lanes that should be ignored carry inverted or scrambled copies, so any leak from them corrupts the result. Separate streams with a premature frame start, a frame line held low too early, a rising and falling frame mismatch, and two-sample frames tell apart resynchronisation, discard, mismatch detection and the single-pair channel mask.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the receive deframer.
// Assumes the sample width is even so it splits into two equal lanes.
package rxd_pkg;
    localparam int SMP_W = 12;             // received sample width
    localparam int OUT_W = 16;             // channel output width
    localparam int NSLOT = 4;              // samples per full frame
    localparam int SLOT_W = $clog2(NSLOT);

    typedef enum logic {
        TRK_HUNT = 1'b0,
        TRK_LOCK = 1'b1
    } trk_state_t;
endpackage

// File: rtl/rxd_edge_merge.sv
`timescale 1ns/1ps
// Merges the rising- and falling-edge captures of one interface cycle into
// a single registered sample word with its frame bit. In lane mode the
// rising edge carries the upper half. Also flags a frame-line disagreement
// between the two edges.
// Assumes SMP_W is even; one sample per clock cycle in both modes.
module rxd_edge_merge #(
    parameter int SMP_W = rxd_pkg::SMP_W,
    localparam int LANE_W = SMP_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane_mode,
    input  logic [SMP_W-1:0]  rise_data,
    input  logic              rise_frame,
    input  logic [LANE_W-1:0] fall_data,
    input  logic              fall_frame,
    output logic [SMP_W-1:0]  s_word,
    output logic              s_frame,
    output logic              s_mis
);
    // Register the merged sample word and frame bit for this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_word  <= '0;
            s_frame <= 1'b0;
            s_mis   <= 1'b0;
        end else if (lane_mode) begin
            s_word  <= {rise_data[LANE_W-1:0], fall_data};
            s_frame <= rise_frame;
            s_mis   <= rise_frame ^ fall_frame;
        end else begin
            s_word  <= rise_data;
            s_frame <= rise_frame;
            s_mis   <= 1'b0;
        end
    end
endmodule

// File: rtl/rxd_frame_tracker.sv
`timescale 1ns/1ps
// Follows the frame-line pattern of the merged sample stream. It locks on a
// low-to-high change of the frame bit, counts sample slots, accepts samples
// that match the expected pattern and drops the frame on any break. It keeps
// a sticky error flag.
// Assumes the mode inputs are static while a frame is in flight.
module rxd_frame_tracker #(
    parameter int NSLOT = rxd_pkg::NSLOT,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              one_ch,
    input  logic              s_frame,
    input  logic              s_mis,
    output logic              acc,
    output logic              last,
    output logic [SLOT_W-1:0] slot,
    output logic              frame_err
);
    import rxd_pkg::*;

    trk_state_t        state, nstate;
    logic [SLOT_W-1:0] cnt, ncnt;
    logic              prev_frame;
    logic              start, want_hi, bad;
    logic [SLOT_W-1:0] half_cnt, last_idx;

    assign half_cnt = one_ch ? SLOT_W'(NSLOT / 4) : SLOT_W'(NSLOT / 2);
    assign last_idx = one_ch ? SLOT_W'(NSLOT / 2 - 1) : SLOT_W'(NSLOT - 1);

    // Decide whether the current sample is accepted, and the next slot.
    always_comb begin
        start   = s_frame & ~prev_frame;
        want_hi = (cnt < half_cnt);
        acc     = 1'b0;
        slot    = cnt;
        bad     = 1'b0;
        nstate  = state;
        ncnt    = cnt;
        if (start && !s_mis) begin
            acc    = 1'b1;
            slot   = '0;
            bad    = (state == TRK_LOCK) && (cnt != '0);
            nstate = TRK_LOCK;
            ncnt   = SLOT_W'(1);
        end else if (state == TRK_LOCK) begin
            if (s_mis || (s_frame != want_hi)) begin
                bad    = 1'b1;
                nstate = TRK_HUNT;
                ncnt   = '0;
            end else begin
                acc  = 1'b1;
                ncnt = (cnt == last_idx) ? '0 : cnt + 1'b1;
            end
        end else if (start) begin
            bad = 1'b1;
        end
        last = acc && (slot == last_idx);
    end

    // Advance the lock state, slot counter and previous frame bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TRK_HUNT;
            cnt        <= '0;
            prev_frame <= 1'b0;
        end else begin
            state      <= nstate;
            cnt        <= ncnt;
            prev_frame <= s_frame;
        end
    end

    // Hold the framing error until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_err <= 1'b0;
        end else if (bad) begin
            frame_err <= 1'b1;
        end
    end
endmodule

// File: rtl/rxd_sample_pack.sv
`timescale 1ns/1ps
// Collects accepted samples by slot and, on the last slot of a frame,
// publishes all active channels at once, sign-extended, with a one-cycle
// valid strobe.
// Assumes a frame is only published when every slot of it was accepted.
module rxd_sample_pack #(
    parameter int SMP_W = rxd_pkg::SMP_W,
    parameter int OUT_W = rxd_pkg::OUT_W,
    parameter int NSLOT = rxd_pkg::NSLOT,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   one_ch,
    input  logic                   acc,
    input  logic                   last,
    input  logic [SLOT_W-1:0]      slot,
    input  logic [SMP_W-1:0]       word,
    output logic [NSLOT*OUT_W-1:0] chan_data,
    output logic [NSLOT-1:0]       chan_valid
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_ch
        localparam bit LOWER = (g < NSLOT / 2);
        logic [SMP_W-1:0] held;
        logic [SMP_W-1:0] src;
        logic [OUT_W-1:0] dout;
        logic             vout;
        logic             active;

        assign active = LOWER || !one_ch;
        assign src    = (slot == SLOT_W'(g)) ? word : held;

        // Store the sample that belongs to this channel's slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held <= '0;
            end else if (acc && (slot == SLOT_W'(g))) begin
                held <= word;
            end
        end

        // Publish the channel sample and strobe when a frame completes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dout <= '0;
                vout <= 1'b0;
            end else begin
                vout <= last && active;
                if (last && active) begin
                    dout <= {{(OUT_W - SMP_W){src[SMP_W-1]}}, src};
                end
            end
        end

        assign chan_data[g*OUT_W +: OUT_W] = dout;
        assign chan_valid[g]               = vout;
    end
endmodule

// File: rtl/rx_frame_deframer.sv
`timescale 1ns/1ps
// Top of the receive deframer. It merges the edge captures, tracks the frame
// pattern and publishes per-channel samples with valid strobes. The enable
// outputs and the single-pair flag mirror their control inputs.
// Assumes both capture ports are already in the clk domain.
module rx_frame_deframer #(
    parameter int SMP_W = rxd_pkg::SMP_W,
    parameter int OUT_W = rxd_pkg::OUT_W,
    parameter int NSLOT = rxd_pkg::NSLOT,
    localparam int LANE_W = SMP_W / 2,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lane_mode,
    input  logic                   one_ch,
    input  logic [SMP_W-1:0]       rise_data,
    input  logic                   rise_frame,
    input  logic [LANE_W-1:0]      fall_data,
    input  logic                   fall_frame,
    input  logic [NSLOT-1:0]       chan_en_cfg,
    output logic [NSLOT*OUT_W-1:0] chan_data,
    output logic [NSLOT-1:0]       chan_valid,
    output logic [NSLOT-1:0]       chan_en,
    output logic                   r1_mode,
    output logic                   frame_err
);
    logic [SMP_W-1:0]  s_word;
    logic              s_frame, s_mis;
    logic              acc, last;
    logic [SLOT_W-1:0] slot;

    assign chan_en = chan_en_cfg;
    assign r1_mode = one_ch;

    rxd_edge_merge #(.SMP_W(SMP_W)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_mode  (lane_mode),
        .rise_data  (rise_data),
        .rise_frame (rise_frame),
        .fall_data  (fall_data),
        .fall_frame (fall_frame),
        .s_word     (s_word),
        .s_frame    (s_frame),
        .s_mis      (s_mis)
    );

    rxd_frame_tracker #(.NSLOT(NSLOT)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .one_ch    (one_ch),
        .s_frame   (s_frame),
        .s_mis     (s_mis),
        .acc       (acc),
        .last      (last),
        .slot      (slot),
        .frame_err (frame_err)
    );

    rxd_sample_pack #(.SMP_W(SMP_W), .OUT_W(OUT_W), .NSLOT(NSLOT)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .one_ch     (one_ch),
        .acc        (acc),
        .last       (last),
        .slot       (slot),
        .word       (s_word),
        .chan_data  (chan_data),
        .chan_valid (chan_valid)
    );
endmodule

// File: rtl/rxd_checker.sv
`timescale 1ns/1ps
// Port-level properties of the receive deframer, attached by bind.
// Assumes the default package widths.
module rxd_checker (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   one_ch,
    input logic [rxd_pkg::NSLOT*rxd_pkg::OUT_W-1:0] chan_data,
    input logic [rxd_pkg::NSLOT-1:0]              chan_valid,
    input logic                                   frame_err
);
    // R5
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_valid != '0) |=> (chan_valid == '0));

    // R5
    valid_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_valid != '0) |-> (chan_valid == (one_ch ? 4'b0011 : 4'b1111)));

    // R6
    upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        one_ch |-> (chan_valid[3:2] == 2'b00));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    // R4
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_valid[0] |-> (chan_data[15:12] == {4{chan_data[11]}}));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_valid == '0) |-> $stable(chan_data));
endmodule

bind rx_frame_deframer rxd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .one_ch     (one_ch),
    .chan_data  (chan_data),
    .chan_valid (chan_valid),
    .frame_err  (frame_err)
);

// File: tb/rx_frame_deframer_test.sv
`timescale 1ns/1ps
module rx_frame_deframer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lane_mode, one_ch;
    logic [11:0] rise_data;
    logic        rise_frame;
    logic [5:0]  fall_data;
    logic        fall_frame;
    logic [3:0]  chan_en_cfg;
    logic [63:0] chan_data;
    logic [3:0]  chan_valid, chan_en;
    logic        r1_mode, frame_err;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  seen_valid = 1'b0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    rx_frame_deframer uut (
        .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .one_ch(one_ch),
        .rise_data(rise_data), .rise_frame(rise_frame), .fall_data(fall_data),
        .fall_frame(fall_frame), .chan_en_cfg(chan_en_cfg), .chan_data(chan_data),
        .chan_valid(chan_valid), .chan_en(chan_en), .r1_mode(r1_mode),
        .frame_err(frame_err)
    );

    // {lane, sample0, sample1, sample2, sample3}
    localparam logic [48:0] VEC [0:7] = '{
        {1'b1, 12'h7FF, 12'h800, 12'h001, 12'hFFF},
        {1'b1, 12'hA5C, 12'h35A, 12'h000, 12'h123},
        {1'b0, 12'h800, 12'h7FF, 12'hC3C, 12'h0F0},
        {1'b0, 12'h5A5, 12'hA5A, 12'hFFE, 12'h002},
        {1'b1, 12'h456, 12'hBCD, 12'hE01, 12'h1FE},
        {1'b0, 12'h000, 12'hFFF, 12'h800, 12'h7FF},
        {1'b1, 12'h9AB, 12'h012, 12'hF00, 12'h0FF},
        {1'b0, 12'h321, 12'hCDE, 12'hAAA, 12'h555}
    };

    function automatic logic [15:0] sx(input logic [11:0] w);
        return {{4{w[11]}}, w};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_raw(input logic lm, input logic [11:0] rd, input logic rf,
                             input logic [5:0] fd, input logic ff);
        lane_mode = lm; rise_data = rd; rise_frame = rf;
        fall_data = fd; fall_frame = ff;
        @(negedge clk);
        if (chan_valid != 4'b0) seen_valid = 1'b1;
    endtask

    // Lane mode scrambles rise_data[11:6]; wide mode scrambles the falling port.
    task automatic drive_slot(input logic lm, input logic [11:0] w, input logic f);
        if (lm) drive_raw(lm, {w[5:0] ^ 6'h15, w[11:6]}, f, w[5:0], f);
        else    drive_raw(lm, w, f, ~w[5:0], ~f);
    endtask

    task automatic send_frame(input logic lm, input logic [47:0] ws);
        for (int s = 0; s < 4; s++) drive_slot(lm, ws[47-12*s -: 12], s < 2);
    endtask

    // Compare all four channels against samples of a 4-slot frame.
    task automatic check_full(input logic [47:0] ws, input string tag);
        chk(chan_valid == 4'hF, {tag, " R5 valid"}, {60'b0, chan_valid}, 64'hF);
        for (int c = 0; c < 4; c++)
            chk(chan_data[16*c +: 16] == sx(ws[47-12*c -: 12]),
                $sformatf("%s R3 R4 ch%0d", tag, c),
                {48'b0, chan_data[16*c +: 16]}, {48'b0, sx(ws[47-12*c -: 12])});
    endtask

    task automatic do_reset(input logic oc);
        rst_n = 1'b0; one_ch = oc;
        drive_slot(1'b0, 12'h000, 1'b0);
        drive_slot(1'b0, 12'h000, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; one_ch = 1'b0; chan_en_cfg = 4'b1010;
        lane_mode = 1'b0; rise_data = 12'hFFF; rise_frame = 1'b0;
        fall_data = 6'h3F; fall_frame = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(chan_data == 64'b0, "R11 data", chan_data, 64'b0);
        chk(chan_valid == 4'b0, "R11 valid", {60'b0, chan_valid}, 64'b0);
        chk(frame_err == 1'b0, "R11 err", {63'b0, frame_err}, 64'b0);
        // R10 mirrors
        chk(chan_en == 4'b1010, "R10 enable", {60'b0, chan_en}, 64'hA);
        chk(r1_mode == 1'b0, "R10 r1_mode", {63'b0, r1_mode}, 64'b0);
        rst_n = 1'b1;

        // R12: no valid while hunting on a low frame line
        seen_valid = 1'b0;
        for (int k = 0; k < 5; k++) drive_slot(k[0], 12'h5A5, 1'b0);
        chk(!seen_valid, "R12 no lock", {63'b0, seen_valid}, 64'b0);

        // Main table, back to back frames
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 4; s++) begin
                drive_slot(VEC[i][48], VEC[i][47-12*s -: 12], s < 2);
                if (s == 0 && i > 0)
                    check_full(VEC[i-1][47:0], VEC[i-1][48] ? "R1" : "R2");
                if (s == 1)
                    chk(chan_valid == 4'b0, "R5 strobe width", {60'b0, chan_valid}, 64'b0);
            end
        end
        drive_slot(1'b1, 12'h111, 1'b1);
        check_full(VEC[7][47:0], "R2");
        chk(frame_err == 1'b0, "R8 clean err", {63'b0, frame_err}, 64'b0);

        // R8: frame line drops at slot 1
        seen_valid = 1'b0;
        drive_slot(1'b1, 12'h222, 1'b0);
        drive_slot(1'b1, 12'h333, 1'b0);
        drive_slot(1'b1, 12'h444, 1'b0);
        chk(frame_err == 1'b1, "R8 err set", {63'b0, frame_err}, 64'b1);
        send_frame(1'b1, {12'h8F1, 12'h0E2, 12'h7D3, 12'hFC4});
        chk(!seen_valid, "R8 discard", {63'b0, seen_valid}, 64'b0);
        drive_slot(1'b1, 12'h000, 1'b1);
        check_full({12'h8F1, 12'h0E2, 12'h7D3, 12'hFC4}, "R8 relock");
        chk(frame_err == 1'b1, "R8 sticky", {63'b0, frame_err}, 64'b1);

        // R11 reset clears published data
        do_reset(1'b0);
        chk(chan_data == 64'b0 && frame_err == 1'b0, "R11 re-reset",
            chan_data, 64'b0);

        // R7: premature start at slot 3 resynchronises
        seen_valid = 1'b0;
        drive_slot(1'b0, 12'h101, 1'b1);
        drive_slot(1'b0, 12'h202, 1'b1);
        drive_slot(1'b0, 12'h303, 1'b0);
        send_frame(1'b0, {12'hE10, 12'h020, 12'h830, 12'h7F0});
        chk(!seen_valid, "R7 partial dropped", {63'b0, seen_valid}, 64'b0);
        drive_slot(1'b0, 12'h000, 1'b1);
        check_full({12'hE10, 12'h020, 12'h830, 12'h7F0}, "R7 resync");
        chk(frame_err == 1'b1, "R7 err", {63'b0, frame_err}, 64'b1);

        // R9: rise/fall frame mismatch in lane mode
        do_reset(1'b0);
        seen_valid = 1'b0;
        drive_raw(1'b1, 12'h015, 1'b1, 6'h2A, 1'b0);
        drive_slot(1'b1, 12'h111, 1'b1);
        drive_slot(1'b1, 12'h222, 1'b0);
        drive_slot(1'b1, 12'h333, 1'b0);
        chk(frame_err == 1'b1, "R9 err", {63'b0, frame_err}, 64'b1);
        send_frame(1'b1, {12'h0AB, 12'hF54, 12'h3C3, 12'hC3C});
        chk(!seen_valid, "R9 no valid", {63'b0, seen_valid}, 64'b0);
        drive_slot(1'b1, 12'h000, 1'b1);
        check_full({12'h0AB, 12'hF54, 12'h3C3, 12'hC3C}, "R9 recover");

        // R6: single pair, 2-sample frames
        do_reset(1'b1);
        chk(r1_mode == 1'b1, "R6 R10 r1_mode", {63'b0, r1_mode}, 64'b1);
        drive_slot(1'b1, 12'h9C4, 1'b1);
        drive_slot(1'b1, 12'h13B, 1'b0);
        drive_slot(1'b0, 12'h7E0, 1'b1);
        chk(chan_valid == 4'b0011, "R6 valid", {60'b0, chan_valid}, 64'h3);
        chk(chan_data == {32'b0, sx(12'h13B), sx(12'h9C4)}, "R6 data lane",
            chan_data, {32'b0, sx(12'h13B), sx(12'h9C4)});
        drive_slot(1'b0, 12'hF81, 1'b0);
        chk(chan_valid == 4'b0, "R6 strobe width", {60'b0, chan_valid}, 64'b0);
        drive_slot(1'b0, 12'h000, 1'b1);
        chk(chan_valid == 4'b0011, "R6 valid wide", {60'b0, chan_valid}, 64'h3);
        chk(chan_data == {32'b0, sx(12'hF81), sx(12'h7E0)}, "R6 data wide",
            chan_data, {32'b0, sx(12'hF81), sx(12'h7E0)});
        chk(frame_err == 1'b0, "R6 no err", {63'b0, frame_err}, 64'b0);

        // R10 enable follows its control
        chan_en_cfg = 4'b0101;
        @(negedge clk);
        chk(chan_en == 4'b0101, "R10 enable change", {60'b0, chan_en}, 64'h5);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule